// File: doc/BRIEF.md
# Memory-LCD Multi-Line Update Serializer

This block drives a 400x240 monochrome memory-in-pixel panel over its three-wire serial link: a chip select, a data line and a serial clock. It writes a run of consecutive display lines in a single chip-select window. The window opens with an 8-clock mode header that carries the update flag and the VCOM/frame-inversion level. Each line then sends an 8-bit gate address followed by 400 pixel bits. Lines are separated by 8 dummy clocks, and the window closes with 16 dummy clocks. Pixel bits are fetched on demand from an external line buffer through a read port that has one cycle of latency.

A transfer is launched with a one-cycle `start_i` pulse. At that pulse the block captures the first line address, the line count, the VCOM level, the serial clock half-period, and three spacing values: lead-in, lead-out and idle gap. `busy_o` stays high until the idle gap has elapsed. `done_o` then pulses for one cycle.

The controller is a five-state machine:
- IDLE waits for a start.
- LEAD raises chip select and waits out the lead-in.
- SHIFT clocks out every bit of the frame.
- LAG holds chip select after the last clock edge.
- GAP holds chip select low for the minimum idle time.

The transitions are:
- IDLE→LEAD on a start with a non-zero count.
- IDLE→IDLE with a done pulse on a start with a zero count.
- LEAD→SHIFT after the lead-in half-periods, at the first rising SCLK edge.
- SHIFT→LAG on the falling edge that ends the last tail dummy bit.
- LAG→GAP after the lead-out half-periods, when chip select falls.
- GAP→IDLE after the idle-gap half-periods, with the done pulse.

Top module: `mlcd_line_streamer`

## Requirements
- R1: After reset, `scs_o`, `sclk_o`, `si_o`, `busy_o` and `done_o` are all low, and `scs_o` and `sclk_o` stay low whenever `busy_o` is low.
- R2: The first 8 bits of a window are the mode header, in this order: bit 0 is 1 (update flag), bit 1 equals the captured `vcom_i`, bit 2 is 0 (clear flag), and bits 3 to 7 are 0.
- R3: Each line starts with its 8-bit gate address sent least significant bit first. The first line's address is `first_line_i`, and each later line's address is one more than the previous line's.
- R4: After each address come exactly 400 pixel bits. Pixel index 0 is sent first. Each bit is the value returned on `rd_data_i` one cycle after a `rd_en_o` request. The request carries `rd_line_o` equal to the line's gate address and `rd_bit_o` equal to the pixel index (0 to 399).
- R5: Between consecutive lines there are exactly 8 dummy bits, and after the last line there are exactly 16 dummy bits. All dummy bits are driven 0.
- R6: `scs_o` rises once per transfer and stays high for all 16+416·N bits, where N is the line count. `sclk_o` is high only while `scs_o` is high.
- R7: `si_o` changes only when `sclk_o` falls or while `sclk_o` is low, and never on a rising edge. Each SCLK high time and each SCLK low time between bits lasts `half_div_i` system cycles.
- R8: The first rising SCLK edge comes `lead_i`·`half_div_i` cycles after `scs_o` rises. `scs_o` falls `lag_i`·`half_div_i` cycles after the last falling SCLK edge.
- R9: After `scs_o` falls, `busy_o` stays high and `done_o` stays low for `gap_i`·`half_div_i` cycles.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The running frame and its bit count are unchanged, and no second window opens.
- R11: A start with `line_cnt_i` = 0 raises `done_o` in the next cycle, never asserts `scs_o`, and leaves `busy_o` low.
- R12: `done_o` is a single-cycle pulse at the end of each transfer, and `busy_o` is low whenever `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one-cycle pulse |
| first_line_i | input | LINE_W | Gate address of the first line (1 to 240) |
| line_cnt_i | input | LINE_W | Number of lines to write |
| vcom_i | input | 1 | VCOM/frame-inversion level sent in the header |
| half_div_i | input | DIV_W | System cycles per SCLK half-period (at least 2) |
| lead_i | input | SPAN_W | Half-periods from chip-select rise to first SCLK edge (at least 1) |
| lag_i | input | SPAN_W | Half-periods from last SCLK edge to chip-select fall (at least 1) |
| gap_i | input | SPAN_W | Half-periods of chip-select low before done (at least 1) |
| rd_en_o | output | 1 | Pixel read request |
| rd_line_o | output | LINE_W | Gate address of the requested pixel's line |
| rd_bit_o | output | IDX_W | Pixel index within the line |
| rd_data_i | input | 1 | Pixel value, valid one cycle after `rd_en_o` |
| scs_o | output | 1 | Panel chip select, active high |
| sclk_o | output | 1 | Serial clock |
| si_o | output | 1 | Serial data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | End-of-transfer pulse |

## Verification
The assertions assume the configuration is legal:
- `half_div_i` is at least 2, so the pixel read issued at a rising edge returns before the next falling edge.
- The lead, lag and gap spans are at least 1.
- `first_line_i + line_cnt_i - 1` does not pass 240.
- `rd_data_i` is valid exactly one cycle after each request.

The stimulus respects these limits. It draws the half-period from 2 to 3, every span from 1 to 4, and the line count from 1 to 3. The start line is drawn so the last line is at most 240. The buffer model answers every request on the next edge. Directed cases cover:
- the top line, 240;
- a start pulse in mid-frame;
- a zero line count.

// File: rtl/mlcd_pkg.sv
package mlcd_pkg;

    localparam int HDR_BITS  = 8;
    localparam int ADDR_BITS = 8;
    localparam int SEP_BITS  = 8;
    localparam int TAIL_BITS = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_LAG,
        ST_GAP
    } mlcd_state_e;

    typedef enum logic [2:0] {
        SEG_HDR,
        SEG_ADDR,
        SEG_DATA,
        SEG_SEP,
        SEG_TAIL,
        SEG_END
    } mlcd_seg_e;

endpackage

// File: rtl/mlcd_half_tick.sv
module mlcd_half_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = en && (cnt_q == div - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/mlcd_cursor.sv
module mlcd_cursor
    import mlcd_pkg::*;
#(
    parameter int LINE_PIXELS = 400,
    parameter int LINE_W      = 8,
    parameter int IDX_W       = 9
) (
    input  mlcd_seg_e         seg,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LINE_W-1:0] line,
    input  logic              last_line,
    output mlcd_seg_e         nseg,
    output logic [IDX_W-1:0]  nidx,
    output logic [LINE_W-1:0] nline
);

    localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_BITS - 1);
    localparam logic [IDX_W-1:0] ADDR_END = IDX_W'(ADDR_BITS - 1);
    localparam logic [IDX_W-1:0] DATA_END = IDX_W'(LINE_PIXELS - 1);
    localparam logic [IDX_W-1:0] SEP_END  = IDX_W'(SEP_BITS - 1);
    localparam logic [IDX_W-1:0] TAIL_END = IDX_W'(TAIL_BITS - 1);

    always_comb begin
        nseg  = seg;
        nidx  = idx + IDX_W'(1);
        nline = line;
        unique case (seg)
            SEG_HDR:  if (idx == HDR_END)  begin nseg = SEG_ADDR; nidx = '0; end
            SEG_ADDR: if (idx == ADDR_END) begin nseg = SEG_DATA; nidx = '0; end
            SEG_DATA: if (idx == DATA_END) begin
                          nseg = last_line ? SEG_TAIL : SEG_SEP;
                          nidx = '0;
                      end
            SEG_SEP:  if (idx == SEP_END) begin
                          nseg  = SEG_ADDR;
                          nidx  = '0;
                          nline = line + LINE_W'(1);
                      end
            SEG_TAIL: if (idx == TAIL_END) begin nseg = SEG_END; nidx = '0; end
            default:  begin nseg = SEG_END; nidx = '0; end
        endcase
    end

endmodule

// File: rtl/mlcd_bit_src.sv
module mlcd_bit_src
    import mlcd_pkg::*;
#(
    parameter int LINE_W = 8,
    parameter int IDX_W  = 9
) (
    input  mlcd_seg_e         seg,
    input  logic [IDX_W-1:0]  idx,
    input  logic [LINE_W-1:0] line,
    input  logic              vcom,
    input  logic              pix,
    output logic              bit_o
);

    always_comb begin
        unique case (seg)
            SEG_HDR:  bit_o = (idx == '0) ? 1'b1 : ((idx == IDX_W'(1)) ? vcom : 1'b0);
            SEG_ADDR: bit_o = line[idx[2:0]];
            SEG_DATA: bit_o = pix;
            default:  bit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/mlcd_line_streamer.sv
module mlcd_line_streamer
    import mlcd_pkg::*;
#(
    parameter  int LINE_PIXELS = 400,
    parameter  int LINE_W      = 8,
    parameter  int DIV_W       = 8,
    parameter  int SPAN_W      = 4,
    localparam int IDX_W       = $clog2(LINE_PIXELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [LINE_W-1:0] first_line_i,
    input  logic [LINE_W-1:0] line_cnt_i,
    input  logic              vcom_i,
    input  logic [DIV_W-1:0]  half_div_i,
    input  logic [SPAN_W-1:0] lead_i,
    input  logic [SPAN_W-1:0] lag_i,
    input  logic [SPAN_W-1:0] gap_i,
    output logic              rd_en_o,
    output logic [LINE_W-1:0] rd_line_o,
    output logic [IDX_W-1:0]  rd_bit_o,
    input  logic              rd_data_i,
    output logic              scs_o,
    output logic              sclk_o,
    output logic              si_o,
    output logic              busy_o,
    output logic              done_o
);

    mlcd_state_e       state_q, state_d;
    mlcd_seg_e         seg_q, nseg;
    logic [IDX_W-1:0]  idx_q, nidx;
    logic [LINE_W-1:0] line_q, nline, last_line_q;
    logic [DIV_W-1:0]  div_q;
    logic [SPAN_W-1:0] lead_q, lag_q, gap_q, span_q;
    logic              vcom_q, pix_q, rd_pend_q;
    logic              scs_q, sclk_q, si_q, done_q;
    logic              tick, rise, fall, nbit;

    mlcd_half_tick #(.DIV_W(DIV_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state_q != ST_IDLE),
        .div   (div_q),
        .tick  (tick)
    );

    mlcd_cursor #(.LINE_PIXELS(LINE_PIXELS), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_cursor (
        .seg       (seg_q),
        .idx       (idx_q),
        .line      (line_q),
        .last_line (line_q == last_line_q),
        .nseg      (nseg),
        .nidx      (nidx),
        .nline     (nline)
    );

    mlcd_bit_src #(.LINE_W(LINE_W), .IDX_W(IDX_W)) u_bit (
        .seg   (nseg),
        .idx   (nidx),
        .line  (nline),
        .vcom  (vcom_q),
        .pix   (pix_q),
        .bit_o (nbit)
    );

    assign rise = tick && (state_q == ST_SHIFT) && !sclk_q;
    assign fall = tick && (state_q == ST_SHIFT) && sclk_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i && (line_cnt_i != '0)) state_d = ST_LEAD;
            ST_LEAD:  if (tick && (span_q == lead_q - SPAN_W'(1))) state_d = ST_SHIFT;
            ST_SHIFT: if (fall && (nseg == SEG_END)) state_d = ST_LAG;
            ST_LAG:   if (tick && (span_q == lag_q - SPAN_W'(1))) state_d = ST_GAP;
            ST_GAP:   if (tick && (span_q == gap_q - SPAN_W'(1))) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // datapath and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_q       <= SEG_HDR;
            idx_q       <= '0;
            line_q      <= '0;
            last_line_q <= '0;
            div_q       <= '0;
            lead_q      <= '0;
            lag_q       <= '0;
            gap_q       <= '0;
            span_q      <= '0;
            vcom_q      <= 1'b0;
            pix_q       <= 1'b0;
            rd_pend_q   <= 1'b0;
            scs_q       <= 1'b0;
            sclk_q      <= 1'b0;
            si_q        <= 1'b0;
            done_q      <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            rd_pend_q <= rd_en_o;
            if (rd_pend_q) pix_q <= rd_data_i;
            if (state_d != state_q) begin
                span_q <= '0;
            end else if (tick) begin
                span_q <= span_q + SPAN_W'(1);
            end
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (line_cnt_i == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            seg_q       <= SEG_HDR;
                            idx_q       <= '0;
                            line_q      <= first_line_i;
                            last_line_q <= first_line_i + line_cnt_i - LINE_W'(1);
                            div_q       <= half_div_i;
                            lead_q      <= lead_i;
                            lag_q       <= lag_i;
                            gap_q       <= gap_i;
                            vcom_q      <= vcom_i;
                            scs_q       <= 1'b1;
                            si_q        <= 1'b1;
                        end
                    end
                end
                ST_LEAD: begin
                    if (state_d == ST_SHIFT) sclk_q <= 1'b1;
                end
                ST_SHIFT: begin
                    if (rise) begin
                        sclk_q <= 1'b1;
                    end else if (fall) begin
                        sclk_q <= 1'b0;
                        seg_q  <= nseg;
                        idx_q  <= nidx;
                        line_q <= nline;
                        si_q   <= nbit;
                    end
                end
                ST_LAG: begin
                    if (state_d == ST_GAP) scs_q <= 1'b0;
                end
                ST_GAP: begin
                    if (state_d == ST_IDLE) done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_en_o   = rise && (nseg == SEG_DATA);
        rd_line_o = nline;
        rd_bit_o  = nidx;
        scs_o     = scs_q;
        sclk_o    = sclk_q;
        si_o      = si_q;
        busy_o    = (state_q != ST_IDLE);
        done_o    = done_q;
    end

endmodule

// File: rtl/mlcd_line_streamer_chk.sv
module mlcd_line_streamer_chk #(
    parameter int LINE_PIXELS = 400,
    parameter int IDX_W       = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             rd_en_o,
    input logic [IDX_W-1:0] rd_bit_o,
    input logic             scs_o,
    input logic             sclk_o,
    input logic             si_o,
    input logic             busy_o,
    input logic             done_o
);

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!scs_o && !sclk_o));

    a_r4_read_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (scs_o && (rd_bit_o < IDX_W'(LINE_PIXELS))));

    a_r6_clock_inside_select: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> scs_o);

    a_r7_si_stable_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(si_o));

    a_r8_select_before_clock: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $past(scs_o));

    a_r10_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (busy_o || done_o));

    a_r12_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

bind mlcd_line_streamer mlcd_line_streamer_chk #(
    .LINE_PIXELS (LINE_PIXELS),
    .IDX_W       (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .rd_en_o  (rd_en_o),
    .rd_bit_o (rd_bit_o),
    .scs_o    (scs_o),
    .sclk_o   (sclk_o),
    .si_o     (si_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
);

// File: tb/mlcd_line_streamer_bench.sv
`timescale 1ns/1ps
module mlcd_line_streamer_bench;

    localparam int LW = 8;
    localparam int DW = 8;
    localparam int SW = 4;
    localparam int IW = 9;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n, start, vcom, rd_en, rd_data, scs, sclk, si, busy, done;
    logic [LW-1:0] first_line, line_cnt, rd_line;
    logic [DW-1:0] half_div;
    logic [SW-1:0] lead, lag, gap;
    logic [IW-1:0] rd_bit;

    mlcd_line_streamer u_mlcd_line_streamer (
        .clk (clk), .rst_n (rst_n), .start_i (start),
        .first_line_i (first_line), .line_cnt_i (line_cnt), .vcom_i (vcom),
        .half_div_i (half_div), .lead_i (lead), .lag_i (lag), .gap_i (gap),
        .rd_en_o (rd_en), .rd_line_o (rd_line), .rd_bit_o (rd_bit), .rd_data_i (rd_data),
        .scs_o (scs), .sclk_o (sclk), .si_o (si), .busy_o (busy), .done_o (done)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    function automatic logic pix(int ln, int b);
        return logic'(((ln * 31) + (b * 7) + (b >> 4) + (ln >> 1)) & 1);
    endfunction

    function automatic logic exp_bit(int k, int first, int cnt, logic vc);
        int r, j, p;
        if (k < 8) return (k == 0) ? 1'b1 : ((k == 1) ? vc : 1'b0);
        r = k - 8;
        if (r >= cnt * 416 - 8) return 1'b0;
        j = r / 416;
        p = r % 416;
        if (p < 8) return logic'(((first + j) >> p) & 1);
        if (p < 408) return pix(first + j, p - 8);
        return 1'b0;
    endfunction

    // 0 header, 1 address, 2 pixel, 3 dummy
    function automatic int kind(int k, int cnt);
        int r, p;
        if (k < 8) return 0;
        r = k - 8;
        if (r >= cnt * 416 - 8) return 3;
        p = r % 416;
        if (p < 8) return 1;
        if (p < 408) return 2;
        return 3;
    endfunction

    task automatic chk(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    // line buffer model, one cycle latency
    always @(posedge clk) rd_data <= rd_en ? pix(int'(rd_line), int'(rd_bit)) : 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WATCHDOG) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // serial-link monitor
    logic cap [0:4095];
    int nbits, windows, dones, width_bad, si_bad, cur_div;
    int scs_rise_c, scs_fall_c, first_rise_c, last_rise_c, last_fall_c, done_c;
    logic p_scs = 1'b0, p_sclk = 1'b0, p_si = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!p_scs && scs) begin
                windows++;
                scs_rise_c = cyc;
                nbits = 0;
            end
            if (p_scs && !scs) scs_fall_c = cyc;
            if (!p_sclk && sclk) begin
                if (nbits == 0) first_rise_c = cyc;
                else if (cyc - last_fall_c != cur_div) width_bad++;
                if (nbits < 4096) cap[nbits] = si;
                nbits++;
                last_rise_c = cyc;
            end
            if (p_sclk && !sclk) begin
                if (cyc - last_rise_c != cur_div) width_bad++;
                last_fall_c = cyc;
            end
            if ((si != p_si) && sclk) si_bad++;
            if (done) begin
                dones++;
                done_c = cyc;
            end
        end
        p_scs  = scs;
        p_sclk = sclk;
        p_si   = si;
    end

    task automatic clear_mon();
        nbits = 0; windows = 0; dones = 0; width_bad = 0; si_bad = 0;
        scs_rise_c = 0; scs_fall_c = 0; first_rise_c = 0; done_c = 0;
    endtask

    task automatic xfer(int f, int n, logic vc, int dv, int ld, int lg, int gp, bit poke);
        int bad [4];
        for (int i = 0; i < 4; i++) bad[i] = 0;
        clear_mon();
        cur_div    = dv;
        @(negedge clk);
        first_line = LW'(f);
        line_cnt   = LW'(n);
        vcom       = vc;
        half_div   = DW'(dv);
        lead       = SW'(ld);
        lag        = SW'(lg);
        gap        = SW'(gp);
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (60) @(negedge clk);
            first_line = 8'd9;
            line_cnt   = 8'd7;
            start      = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (dones == 0) @(negedge clk);
        repeat (4) @(negedge clk);
        for (int k = 0; k < 16 + 416 * n; k++) begin
            if (k < nbits && cap[k] !== exp_bit(k, f, n, vc)) bad[kind(k, n)]++;
        end
        chk("R2 header bits", bad[0], 0);
        chk("R3 address bits", bad[1], 0);
        chk("R4 pixel bits", bad[2], 0);
        chk("R5 dummy bits", bad[3], 0);
        chk("R6 bit count", nbits, 16 + 416 * n);
        chk("R6 select windows", windows, 1);
        chk("R7 sclk widths", width_bad, 0);
        chk("R7 si moves while sclk high", si_bad, 0);
        chk("R8 lead-in cycles", first_rise_c - scs_rise_c, ld * dv);
        chk("R8 lead-out cycles", scs_fall_c - last_fall_c, lg * dv);
        chk("R9 idle gap cycles", done_c - scs_fall_c, gp * dv);
        chk("R12 done pulses", dones, 1);
        chk("R12 busy after done", int'(busy), 0);
        if (poke) chk("R10 restart ignored", windows + nbits, 1 + 16 + 416 * n);
    endtask

    initial begin
        int n, f;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; start = 1'b0; vcom = 1'b0;
        first_line = '0; line_cnt = '0; half_div = 8'd2;
        lead = 4'd1; lag = 4'd1; gap = 4'd1;
        cur_div = 2;
        clear_mon();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", int'({scs, sclk, si, busy, done}), 0);

        xfer(1, 3, 1'b1, 2, 1, 1, 1, 1'b0);
        xfer(240, 1, 1'b0, 3, 4, 4, 4, 1'b0);
        xfer(100, 2, 1'b0, 2, 2, 3, 1, 1'b1);

        // zero line count
        clear_mon();
        @(negedge clk);
        line_cnt = '0;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 done next cycle", int'(done), 1);
        chk("R11 busy stays low", int'(busy), 0);
        repeat (10) @(negedge clk);
        chk("R11 no select window", windows, 0);

        for (int t = 0; t < 10; t++) begin
            n = 1 + int'($urandom % 3);
            f = 1 + int'($urandom % (241 - n));
            xfer(f, n, logic'($urandom % 2), 2 + int'($urandom % 2),
                 1 + int'($urandom % 4), 1 + int'($urandom % 4),
                 1 + int'($urandom % 4), 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule